// File: doc/BRIEF.md
# Read-Modify-Write Store Unit

This block holds a small synchronous RAM whose rows are 64 bits wide and performs stores of three sizes into it without byte-lane write strobes. A double-word store overwrites a whole row. A word store or byte store first reads the addressed row. It then replaces only the selected 32-bit half or 8-bit lane with the low bits of the store data, and writes the merged row back. Bits outside the target are left unchanged.

The store address is a byte address, and its row index is the address shifted right by three. Sub-word stores take two cycles. In the first the unit reads the row and raises busy. In the second it writes the merged row and raises done one cycle later. A double-word store skips the read and finishes in one cycle. A separate registered read port returns a whole row for loads. The RAM is cleared at reset.

Top module: `rmw_store_unit`

## Requirements
- R1: While reset is asserted and after its release, busy and done are 0, ld_data is 0 and every RAM row reads as 0.
- R2: A double-word store writes all 64 bits of st_data into row st_addr>>3, and address bits [2:0] have no effect on it.
- R3: A word store with st_addr[2]=0 replaces row bits [31:0] with st_data[31:0] and keeps bits [63:32].
- R4: A word store with st_addr[2]=1 replaces row bits [63:32] with st_data[31:0] and keeps bits [31:0]. Address bits [1:0] have no effect on a word store.
- R5: A byte store replaces row bits [8*k+7:8*k] with st_data[7:0], where k=st_addr[2:0], and keeps all other bits.
- R6: st_size encodes the store size: 2'b00 selects a byte, 2'b01 a word, and 2'b10 or 2'b11 a double word.
- R7: A sub-word store accepted on a clock edge raises busy for exactly the next cycle. It writes the row on the following edge and raises done for one cycle after that edge.
- R8: A double-word store accepted on a clock edge writes the row on that edge and raises done for the next cycle, while busy stays 0.
- R9: A store request presented while busy is 1 is ignored and changes no RAM row.
- R10: On each clock edge ld_data takes the row at ld_idx as it was before any write made on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_req | input | 1 | Store request, sampled on the clock edge |
| st_addr | input | IW+3 | Store byte address |
| st_size | input | 2 | Store size (00 byte, 01 word, 1x double word) |
| st_data | input | 64 | Store data; low bits are used for sub-word stores |
| busy | output | 1 | Sub-word store is in its merge cycle; requests are ignored |
| done | output | 1 | One-cycle pulse after a store has been written |
| ld_idx | input | IW | Row index for the load read port |
| ld_data | output | 64 | Registered row read for loads |

## Verification
A wrong merge selection or a stale captured row corrupts bits next to the target. This shows at ld_data one cycle after that row is addressed on the read port, and the bench reads back stored rows and compares them with a behavioural memory model. A sequencing fault, such as a busy phase that lasts too long, a missing done pulse or a request accepted while busy, shows on busy or done in the very next cycle. Those outputs are compared with the model on every clock.

// File: rtl/rmw_store_unit.sv
module rmw_store_unit #(
  parameter int DEPTH = 256,
  localparam int IW = $clog2(DEPTH),
  localparam int AW = IW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_req,
  input  logic [AW-1:0] st_addr,
  input  logic [1:0]    st_size,
  input  logic [63:0]   st_data,
  output logic          busy,
  output logic          done,
  input  logic [IW-1:0] ld_idx,
  output logic [63:0]   ld_data
);

  logic [63:0]   mem [DEPTH];
  logic [63:0]   old_q;
  logic [63:0]   merged;
  logic [AW-1:0] addr_q;
  logic [31:0]   data_q;
  logic          word_q;

  wire          accept = st_req & ~busy;
  wire          is_dw  = st_size[1];
  wire [IW-1:0] row_in = st_addr[AW-1:3];

  always_comb begin
    merged = old_q;
    if (word_q) begin
      if (addr_q[2]) merged[63:32] = data_q;
      else           merged[31:0]  = data_q;
    end else begin
      merged[{addr_q[2:0], 3'b000} +: 8] = data_q[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      old_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      word_q  <= 1'b0;
      ld_data <= '0;
    end else begin
      ld_data <= mem[ld_idx];
      busy    <= 1'b0;
      done    <= 1'b0;
      if (busy) begin
        mem[addr_q[AW-1:3]] <= merged;
        done <= 1'b1;
      end else if (accept) begin
        if (is_dw) begin
          mem[row_in] <= st_data;
          done <= 1'b1;
        end else begin
          old_q  <= mem[row_in];
          addr_q <= st_addr;
          data_q <= st_data[31:0];
          word_q <= st_size[0];
          busy   <= 1'b1;
        end
      end
    end
  end

  // R7
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R7
  done_after_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done);

  // R7
  sub_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !busy && !st_size[1]) |=> busy);

  // R8
  dw_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !busy && st_size[1]) |=> (done && !busy));

  // R9
  held_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(addr_q) && $stable(data_q) && $stable(word_q)));

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!busy && !done));

endmodule

// File: tb/rmw_store_unit_test.sv
module rmw_store_unit_test;
  localparam int DEPTH = 256;
  localparam int IW = $clog2(DEPTH);
  localparam int AW = IW + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_req = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [1:0]    st_size = '0;
  logic [63:0]   st_data = '0;
  logic [IW-1:0] ld_idx = '0;
  logic          busy, done;
  logic [63:0]   ld_data;

  rmw_store_unit #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .st_req(st_req), .st_addr(st_addr),
    .st_size(st_size), .st_data(st_data), .busy(busy), .done(done),
    .ld_idx(ld_idx), .ld_data(ld_data)
  );

  always #10 clk = ~clk;

  int    vectors = 0;
  int    miscompares = 0;
  string tag = "R1";

  logic [63:0]   mm [DEPTH];
  logic          m_busy, m_done;
  logic [63:0]   m_ld;
  logic [AW-1:0] p_addr;
  logic [63:0]   p_data;
  logic [1:0]    p_size;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mm[i] = '0;
      m_busy = 0; m_done = 0; m_ld = '0;
    end else begin
      logic [63:0] nld;
      logic nb, nd;
      int row, lane;
      nld = mm[ld_idx];
      nb = 0; nd = 0;
      if (m_busy) begin
        row = int'(p_addr) / 8;
        if (p_size == 2'b01) begin
          lane = p_addr[2] ? 32 : 0;
          for (int b = 0; b < 32; b++) mm[row][lane + b] = p_data[b];
        end else begin
          lane = int'(p_addr) % 8;
          for (int b = 0; b < 8; b++) mm[row][lane * 8 + b] = p_data[b];
        end
        nd = 1;
      end else if (st_req) begin
        if (st_size >= 2) begin
          mm[int'(st_addr) / 8] = st_data;
          nd = 1;
        end else begin
          p_addr = st_addr; p_data = st_data; p_size = st_size;
          nb = 1;
        end
      end
      m_ld = nld; m_busy = nb; m_done = nd;
    end
  end

  task automatic cmp(input logic [63:0] act, input logic [63:0] exp, input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cmp({63'b0, busy}, {63'b0, m_busy}, "busy");
      cmp({63'b0, done}, {63'b0, m_done}, "done");
      cmp(ld_data, m_ld, "ld_data");
    end
  end

  task automatic store(input logic [AW-1:0] a, input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    st_req = 1; st_addr = a; st_size = s; st_data = d;
    @(negedge clk);
    st_req = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_chk(input logic [IW-1:0] r, input logic [63:0] exp, input string t);
    @(negedge clk);
    ld_idx = r;
    @(negedge clk);
    tag = t;
    cmp(ld_data, exp, "readback");
  endtask

  initial begin
    #4000000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    cmp({62'b0, busy, done}, 64'd0, "busy/done in reset");
    cmp(ld_data, 64'd0, "ld_data in reset");
    rst_n = 1;
    read_chk(0, 64'd0, "R1");
    read_chk(8'd255, 64'd0, "R1");

    tag = "R2"; store(11'h013, 2'b10, 64'h0123_4567_89AB_CDEF);
    read_chk(2, 64'h0123_4567_89AB_CDEF, "R2");
    tag = "R3"; store(11'h010, 2'b01, 64'hFFFF_FFFF_1111_2222);
    read_chk(2, 64'h0123_4567_1111_2222, "R3");
    tag = "R4"; store(11'h017, 2'b01, 64'hEEEE_EEEE_3333_4444);
    read_chk(2, 64'h3333_4444_1111_2222, "R4");
    tag = "R5"; store(11'h015, 2'b00, 64'hFFFF_FFFF_FFFF_FFAB);
    read_chk(2, 64'h3333_AB44_1111_2222, "R5");
    tag = "R6"; store(11'h020, 2'b11, 64'hDEAD_BEEF_CAFE_F00D);
    read_chk(4, 64'hDEAD_BEEF_CAFE_F00D, "R6");

    tag = "R7";
    @(negedge clk);
    st_req = 1; st_addr = 11'h010; st_size = 2'b00; st_data = 64'h5A;
    @(negedge clk);
    cmp({63'b0, busy}, 64'd1, "busy after sub-word accept");
    tag = "R9";
    st_addr = 11'h010; st_size = 2'b10; st_data = '1;
    @(negedge clk);
    st_req = 0;
    tag = "R7";
    cmp({63'b0, done}, 64'd1, "done after merge");
    repeat (2) @(negedge clk);
    read_chk(2, 64'h3333_AB44_1111_225A, "R9");

    tag = "R8";
    @(negedge clk);
    st_req = 1; st_addr = 11'h028; st_size = 2'b10; st_data = 64'h1;
    @(negedge clk);
    st_req = 0;
    cmp({62'b0, busy, done}, 64'd1, "dw busy/done");
    ld_idx = 5;
    @(negedge clk);
    @(negedge clk);
    tag = "R10";
    cmp(ld_data, 64'h1, "load port");

    tag = "R10";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      st_req  = ($urandom % 3) != 0;
      st_addr = AW'($urandom % 64);
      st_size = 2'($urandom);
      st_data = {$urandom, $urandom};
      ld_idx  = IW'($urandom % 8);
    end
    @(negedge clk);
    st_req = 0;
    repeat (4) @(negedge clk);
    for (int r = 0; r < 8; r++) read_chk(IW'(r), mm[r], "R5");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule